// File: doc/BRIEF.md
# Serial Word Alignment Trainer

This block takes one serial bit stream from a high-speed receive link and recovers its 10-bit word boundary. The bits arrive already bit-aligned and sampled on the recovered bit clock, one bit per clock. Each word is sent most significant bit first. While the transmitter sends its idle-time training word, the block checks all ten possible boundary positions at once. It picks the position where the programmed training word appears. It declares lock after that position has repeated for a set number of consecutive words. After lock it delivers framed parallel words with a strobe.

The host programs the training word on a port and tells the block when training is expected (after start-up and in frame or line overhead). It must not enable image capture until `locked` is high. Lock can be dropped by a one-cycle realign request, and the search then starts again. A receiver uses one instance per data or sync link.

The controller has three states:
- ST_SEARCH: looks for the training word at any offset. A match moves it to ST_CONFIRM, which is the transition *candidate found*.
- ST_CONFIRM: counts consecutive matches at the held offset. The Nth match moves it to ST_LOCKED (*confirmed*). A miss, or a word tick without training expected, moves it back to ST_SEARCH (*broken*).
- ST_LOCKED: holds the offset. A realign request from any state moves the controller to ST_SEARCH (*realign*).

Top module: `ser_word_align`

## Requirements
- R1: While reset is asserted and after it is released, `locked` and `word_vld` are 0 and `word_out` is all zeros, until the first lock.
- R2: A word tick occurs on every 10th bit clock, the first on the 10th rising edge after reset release. At a tick, every offset k from 0 to 9 is tested. Offset k is the 10-bit word whose last bit arrived k clocks before the current bit. The earliest of its bits lands in bit 9.
- R3: A match is considered only at a tick where `train_en` is 1. A tick with `train_en` 0 never starts or advances a lock. In ST_CONFIRM such a tick returns the controller to ST_SEARCH.
- R4: `locked` rises at the tick where the training word has matched at the same offset on CONFIRM_N consecutive ticks (default 4). In ST_SEARCH, when several offsets match, the lowest k is held.
- R5: In ST_CONFIRM, a tick without a match at the held offset returns the controller to ST_SEARCH with the count cleared. That tick does not start a new candidate.
- R6: In ST_LOCKED, the offset is frozen. Matches at other offsets and the value of `train_en` have no effect, and `locked` stays 1 until a realign.
- R7: In ST_LOCKED, every tick raises `word_vld` for exactly one cycle, with `word_out` set to the word at the frozen offset, MSB first. The first valid word comes at the tick after lock. `word_out` holds its value between strobes.
- R8: `realign` high at a rising edge clears `locked` and `word_vld` at that edge and restarts the search. It takes priority over any tick at the same edge.
- R9: The training word is read from `train_word` at each tick. A new value applies from the next tick onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Serial data bit, sampled on each rising edge |
| train_en | input | 1 | High while the link is expected to carry training words |
| train_word | input | 10 | Programmed training word |
| realign | input | 1 | One-cycle request to drop lock and search again |
| word_out | output | 10 | Aligned parallel word |
| word_vld | output | 1 | One-cycle strobe marking a new `word_out` |
| locked | output | 1 | Word boundary found and frozen |

## Verification
The hardest case to reach from the ports is a confirmation that breaks part way through the count. The stimulus sends training words, then one word that differs, then training words again at the same boundary. From outside, this can be seen only as lock arriving later than usual.

A second hard case is a boundary that moves while lock is held. The stimulus inserts stray bits between words, so the frozen offset keeps delivering misframed words without losing lock. A realign issued on the first bit of a word, and a change of training word issued together with a realign, exercise the restart paths.

A behavioural model in the bench keeps the raw bit history in a queue. It predicts lock, strobe and word on every clock.

// File: rtl/swa_pkg.sv
`timescale 1ns/1ps
package swa_pkg;

    typedef enum logic [1:0] {
        ST_SEARCH  = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2
    } swa_state_e;

endpackage

// File: rtl/swa_window.sv
`timescale 1ns/1ps
// Sliding bit history plus the word-tick phase counter.
module swa_window #(
    parameter int WORD_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_in,
    output logic [2*WORD_W-2:0]   win_now,
    output logic                  tick
);
    localparam int SPAN = 2 * WORD_W - 1;
    localparam int PH_W = $clog2(WORD_W);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(WORD_W - 1);

    logic [SPAN-2:0] win_q;
    logic [PH_W-1:0] phase_q;

    // Newest bit sits at index 0.
    assign win_now = {win_q, bit_in};
    assign tick    = (phase_q == PH_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q   <= '0;
            phase_q <= '0;
        end else begin
            win_q   <= win_now[SPAN-2:0];
            phase_q <= tick ? '0 : phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/swa_matcher.sv
`timescale 1ns/1ps
// Compares every candidate offset against the training word in parallel.
module swa_matcher #(
    parameter int WORD_W = 10,
    parameter int OFF_W  = $clog2(WORD_W)
) (
    input  logic [2*WORD_W-2:0] win_now,
    input  logic [WORD_W-1:0]   train_word,
    output logic [WORD_W-1:0]   hit_vec,
    output logic                first_hit,
    output logic [OFF_W-1:0]    first_off
);
    for (genvar k = 0; k < WORD_W; k++) begin : g_cand
        assign hit_vec[k] = (win_now[k +: WORD_W] == train_word);
    end

    // Lowest matching offset wins.
    always_comb begin
        first_off = '0;
        for (int k = WORD_W - 1; k >= 0; k--) begin
            if (hit_vec[k]) first_off = OFF_W'(k);
        end
        first_hit = |hit_vec;
    end
endmodule

// File: rtl/swa_fsm.sv
`timescale 1ns/1ps
// Search / confirm / locked controller.
module swa_fsm
    import swa_pkg::*;
#(
    parameter int WORD_W    = 10,
    parameter int CONFIRM_N = 4,
    parameter int OFF_W     = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              train_en,
    input  logic              realign,
    input  logic [WORD_W-1:0] hit_vec,
    input  logic              first_hit,
    input  logic [OFF_W-1:0]  first_off,
    output swa_state_e        st_q,
    output logic [OFF_W-1:0]  off_q,
    output logic              locked
);
    localparam int CNT_W = $clog2(CONFIRM_N + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONFIRM_N - 1);

    swa_state_e       st_d;
    logic [OFF_W-1:0] off_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             held_hit;

    always_comb begin
        held_hit = 1'b0;
        for (int k = 0; k < WORD_W; k++) begin
            if (off_q == OFF_W'(k)) held_hit = hit_vec[k];
        end
    end

    // Next-state logic.
    always_comb begin
        st_d  = st_q;
        off_d = off_q;
        cnt_d = cnt_q;
        if (realign) begin
            st_d  = ST_SEARCH;
            cnt_d = '0;
        end else if (tick) begin
            unique case (st_q)
                ST_SEARCH: begin
                    if (train_en && first_hit) begin
                        off_d = first_off;
                        cnt_d = CNT_W'(1);
                        st_d  = (CONFIRM_N == 1) ? ST_LOCKED : ST_CONFIRM;
                    end
                end
                ST_CONFIRM: begin
                    if (train_en && held_hit) begin
                        cnt_d = cnt_q + 1'b1;
                        if (cnt_q == CNT_LAST) st_d = ST_LOCKED;
                    end else begin
                        st_d  = ST_SEARCH;
                        cnt_d = '0;
                    end
                end
                ST_LOCKED: begin
                    st_d = ST_LOCKED;
                end
                default: begin
                    st_d  = ST_SEARCH;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_SEARCH;
            off_q <= '0;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            off_q <= off_d;
            cnt_q <= cnt_d;
        end
    end

    // Outputs.
    always_comb begin
        locked = (st_q == ST_LOCKED);
    end
endmodule

// File: rtl/swa_extract.sv
`timescale 1ns/1ps
// Selects the frozen offset and registers the framed word and strobe.
module swa_extract
    import swa_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int OFF_W  = $clog2(WORD_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                realign,
    input  swa_state_e          st_q,
    input  logic [OFF_W-1:0]    off_q,
    input  logic [2*WORD_W-2:0] win_now,
    output logic [WORD_W-1:0]   word_out,
    output logic                word_vld
);
    logic [WORD_W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int k = 0; k < WORD_W; k++) begin
            if (off_q == OFF_W'(k)) sel = win_now[k +: WORD_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_out <= '0;
            word_vld <= 1'b0;
        end else if (realign) begin
            word_vld <= 1'b0;
        end else if (tick && st_q == ST_LOCKED) begin
            word_out <= sel;
            word_vld <= 1'b1;
        end else begin
            word_vld <= 1'b0;
        end
    end
endmodule

// File: rtl/ser_word_align.sv
`timescale 1ns/1ps
module ser_word_align
    import swa_pkg::*;
#(
    parameter int WORD_W    = 10,
    parameter int CONFIRM_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              train_en,
    input  logic [WORD_W-1:0] train_word,
    input  logic              realign,
    output logic [WORD_W-1:0] word_out,
    output logic              word_vld,
    output logic              locked
);
    localparam int OFF_W = $clog2(WORD_W);
    localparam int SPAN  = 2 * WORD_W - 1;

    logic [SPAN-1:0]   win_now;
    logic              tick;
    logic [WORD_W-1:0] hit_vec;
    logic              first_hit;
    logic [OFF_W-1:0]  first_off;
    logic [OFF_W-1:0]  off_q;
    swa_state_e        st_q;

    swa_window #(.WORD_W(WORD_W)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (bit_in),
        .win_now (win_now),
        .tick    (tick)
    );

    swa_matcher #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_matcher (
        .win_now    (win_now),
        .train_word (train_word),
        .hit_vec    (hit_vec),
        .first_hit  (first_hit),
        .first_off  (first_off)
    );

    swa_fsm #(.WORD_W(WORD_W), .CONFIRM_N(CONFIRM_N), .OFF_W(OFF_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .train_en  (train_en),
        .realign   (realign),
        .hit_vec   (hit_vec),
        .first_hit (first_hit),
        .first_off (first_off),
        .st_q      (st_q),
        .off_q     (off_q),
        .locked    (locked)
    );

    swa_extract #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_extract (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .realign  (realign),
        .st_q     (st_q),
        .off_q    (off_q),
        .win_now  (win_now),
        .word_out (word_out),
        .word_vld (word_vld)
    );
endmodule

// File: rtl/swa_chk.sv
`timescale 1ns/1ps
module swa_chk #(
    parameter int WORD_W = 10,
    parameter int OFF_W  = $clog2(WORD_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             realign,
    input logic             train_en,
    input logic             word_vld,
    input logic             locked,
    input logic [OFF_W-1:0] off_q
);
    // Cycles since the last strobe while lock is held.
    logic [15:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                gap_q <= '0;
        else if (!locked)          gap_q <= '0;
        else if (word_vld)         gap_q <= 16'd1;
        else if (gap_q != 16'hFFFF && gap_q != 16'd0) gap_q <= gap_q + 16'd1;
    end

    // R7
    vld_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && gap_q != 16'd0) |-> (gap_q == 16'(WORD_W)));

    // R7
    vld_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> locked);

    // R8
    realign_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> (!locked && !word_vld));

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !realign) |=> (locked && $stable(off_q)));

    // R3
    lock_needs_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(train_en));
endmodule

bind ser_word_align swa_chk #(.WORD_W(WORD_W)) u_swa_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .realign  (realign),
    .train_en (train_en),
    .word_vld (word_vld),
    .locked   (locked),
    .off_q    (off_q)
);

// File: tb/test_ser_word_align.sv
`timescale 1ns/1ps
module test_ser_word_align;
    localparam int W      = 10;
    localparam int CONF_N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bit_in = 1'b0;
    logic         train_en = 1'b0;
    logic [W-1:0] train_word = 10'h394;
    logic         realign = 1'b0;
    logic [W-1:0] word_out;
    logic         word_vld;
    logic         locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic rl_req = 1'b0;
    logic [W-1:0] last_word = '0;

    always #2 clk = ~clk;

    ser_word_align #(.WORD_W(W), .CONFIRM_N(CONF_N)) i_ser_word_align (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .train_en(train_en),
        .train_word(train_word), .realign(realign),
        .word_out(word_out), .word_vld(word_vld), .locked(locked)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit hist[$];
    int edge_n, mst, moff, mcnt;
    logic exp_locked, exp_vld;
    logic [W-1:0] exp_word;

    function automatic logic [W-1:0] cand(input int k);
        logic [W-1:0] w;
        for (int i = 0; i < W; i++) w[W-1-i] = hist[hist.size() - 1 - k - (W - 1) + i];
        return w;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist.delete();
            for (int i = 0; i < 2 * W; i++) hist.push_back(1'b0);
            edge_n = 0; mst = 0; moff = 0; mcnt = 0;
            exp_locked = 1'b0; exp_vld = 1'b0; exp_word = '0;
        end else begin
            bit is_tick;
            hist.push_back(bit_in);
            if (hist.size() > 2 * W) void'(hist.pop_front());
            is_tick = (edge_n % W == W - 1);
            edge_n++;
            exp_vld = 1'b0;
            if (realign) begin
                mst = 0; mcnt = 0;
            end else if (is_tick) begin
                if (mst == 2) begin
                    exp_vld = 1'b1;
                    exp_word = cand(moff);
                end else if (mst == 0) begin
                    if (train_en) begin
                        for (int k = W - 1; k >= 0; k--)
                            if (cand(k) == train_word) moff = k;
                        for (int k = 0; k < W; k++)
                            if (cand(k) == train_word) begin
                                mcnt = 1; mst = (CONF_N == 1) ? 2 : 1;
                            end
                    end
                end else begin
                    if (train_en && cand(moff) == train_word) begin
                        mcnt++;
                        if (mcnt == CONF_N) mst = 2;
                    end else begin
                        mst = 0; mcnt = 0;
                    end
                end
            end
            exp_locked = (mst == 2);
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(locked === exp_locked, "R4 lock", locked, exp_locked);
            check(word_vld === exp_vld, "R7 strobe", word_vld, exp_vld);
            check(word_out === exp_word, "R7 word", word_out, exp_word);
            if (word_vld) last_word = word_out;
        end
    end

    // ---------------- stimulus ----------------
    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in  = b;
        realign = rl_req;
        rl_req  = 1'b0;
    endtask

    task automatic send_word(input logic [W-1:0] w);
        for (int i = W - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic realign_word(input logic [W-1:0] w, input string req);
        rl_req = 1'b1;
        send_bit(w[W-1]);
        @(posedge clk); #1;
        check(locked == 1'b0 && word_vld == 1'b0, req, locked, 0);
        for (int i = W - 2; i >= 0; i--) send_bit(w[i]);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(locked == 1'b0 && word_vld == 1'b0 && word_out == '0, "R1 in reset", word_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(locked == 1'b0 && word_vld == 1'b0 && word_out == '0, "R1 after reset", locked, 0);

        // R3: training words with training not expected
        repeat (3) send_bit(1'b0);
        repeat (6) send_word(10'h394);
        check(locked == 1'b0, "R3 no lock without train_en", locked, 0);

        // R4 / R2: lock at a boundary three bits off the tick grid
        train_en = 1'b1;
        repeat (8) send_word(10'h394);
        check(locked == 1'b1, "R4 lock reached", locked, 1);
        check(last_word == 10'h394, "R2 MSB-first framing", last_word, 10'h394);

        // R7: data words after lock
        train_en = 1'b0;
        repeat (10) send_word(W'($urandom_range(0, 1023)));

        // R6: boundary moves by four bits while locked
        train_en = 1'b1;
        repeat (4) send_bit(1'b0);
        repeat (6) send_word(10'h394);
        check(locked == 1'b1, "R6 lock held", locked, 1);
        check(last_word != 10'h394, "R6 offset frozen", last_word, 0);

        // R8: realign and relock at the new boundary
        realign_word(10'h394, "R8 realign drops lock");
        repeat (7) send_word(10'h394);
        check(locked == 1'b1, "R8 relock", locked, 1);
        check(last_word == 10'h394, "R8 new offset", last_word, 10'h394);

        // R5: a broken confirmation
        realign_word(10'h394, "R5 realign");
        send_word(10'h394);
        send_word(10'h000);
        repeat (3) send_word(10'h394);
        check(locked == 1'b0, "R5 count restarted", locked, 0);
        repeat (2) send_word(10'h394);
        check(locked == 1'b1, "R5 lock after restart", locked, 1);

        // R9: new training word
        train_word = 10'h0B6;
        realign_word(10'h0B6, "R9 realign");
        repeat (8) send_word(10'h0B6);
        check(locked == 1'b1, "R9 lock on new word", locked, 1);
        check(last_word == 10'h0B6, "R9 framed new word", last_word, 10'h0B6);

        repeat (5) send_bit(1'b0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule